// File: doc/BRIEF.md
# Six-Channel Decimating Column Loader

This block takes a stream of 10-bit pixel codes from one shared input bus and hands them out, one word per active edge, into six channel registers. A start strobe arms the sequencer; the word on the following active edge goes to the first channel and each later active edge fills the next one, until all six are filled. A transfer strobe then copies all six first-stage registers into second-stage output registers at one instant. Loading of the next line can therefore overlap the display of the current one.

The block runs on one fast clock at twice the pixel rate. A phase input marks which fast cycles stand for rising pixel-clock edges and which stand for falling ones. A static edge-select input picks the active phase, so two instances on one bus and clock can interleave twelve columns: one takes the even words and the other the odd words. A static direction input sets the fill order. Each held code is also presented as a signed offset about a midpoint, and the polarity of that offset follows an invert flag. A standby input wipes all stored data.

Top module: `colfeed_loader`

## Requirements
- R1: After reset, every held code is 0, every fill flag is 0, the done pulse is low, and with invert low every offset reads -1023.
- R2: A start strobe that is high on one active phase makes the word on the next active phase go into the first channel. Each following active phase writes the next channel.
- R3: With edge_sel_i high the active phase is a cycle with rise_ph_i high. With edge_sel_i low it is a cycle with rise_ph_i low. Words and strobes on the other phase are ignored.
- R4: With rev_i low the fill order is channel 0 up to channel 5. With rev_i high it is channel 5 down to channel 0. Channel i sits in bits [10*i+9:10*i] of hold_code_o, and bit 9 is the MSB.
- R5: After the sixth word, done_o is high for one cycle. Later words are ignored until a new start strobe is seen.
- R6: A start strobe during a sequence restarts it, so the word on the next active phase goes into the first channel.
- R7: xfr_i high in a cycle with rise_ph_i high copies all six first-stage codes to hold_code_o in the next cycle, which has rise_ph_i low. This holds in both edge modes. Until then, hold_code_o keeps its old values.
- R8: For held code n, the offset in bits [11*i+10:11*i] of offset_o is -(1023-n) with inv_i low and +(1023-n) with inv_i high, in 11-bit two's complement.
- R9: While stby_i is high, the first-stage codes, held codes, fill flags, pending transfer and sequencer state are cleared. Loading works normally after stby_i returns low.
- R10: Bit i of fill_o is set when channel i is written. A new sequence clears all bits except the bit of its first channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, two cycles per pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rise_ph_i | input | 1 | High in cycles that stand for a rising pixel edge |
| edge_sel_i | input | 1 | Static: 1 selects the rising phase, 0 selects the falling phase |
| rev_i | input | 1 | Static fill direction: 0 ascending, 1 descending |
| start_i | input | 1 | Start-of-sequence strobe |
| xfr_i | input | 1 | Transfer request, sampled on the rising phase |
| inv_i | input | 1 | Offset polarity select |
| stby_i | input | 1 | Standby: clears all stored state |
| word_i | input | 10 | Shared pixel code bus |
| hold_code_o | output | 60 | Six held codes, packed |
| offset_o | output | 66 | Six signed offsets, packed |
| fill_o | output | 6 | Per-channel written-this-sequence flags |
| done_o | output | 1 | One-cycle pulse after the sixth load |

## Verification
The bench drives words on both phases in each edge mode. A design that sampled the wrong phase would then hold the decoy words. Descending fills are checked through both the held codes and the partial fill flags, which catches an order that is mirrored or shifted by one. The bench starts a new sequence while the old codes are still displayed. A design without a real second stage, or one that fires the transfer on the rising phase, would show partly loaded lines. Further cases are a restart strobe in mid-sequence, standby in mid-sequence, words after the sixth one, and the codes 0 and 1023 under both polarities. A design that kept stale state or got the offset sign wrong would show the wrong codes or offsets.

// File: rtl/colfeed_pkg.sv
package colfeed_pkg;
  localparam int unsigned CF_NCH = 6;
  localparam int unsigned CF_DW  = 10;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_st_e;
endpackage

// File: rtl/colfeed_seq.sv
module colfeed_seq
  import colfeed_pkg::*;
#(
  parameter int unsigned NCH = CF_NCH
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stby_i,
  input  logic           rise_ph_i,
  input  logic           edge_sel_i,
  input  logic           rev_i,
  input  logic           start_i,
  input  logic           xfr_i,
  output logic [NCH-1:0] wr_en_o,
  output logic [NCH-1:0] fill_o,
  output logic           done_o,
  output logic           xfr_go_o
);
  localparam int unsigned PW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [PW-1:0] LAST = PW'(NCH - 1);

  seq_st_e        st_q, st_d;
  logic [PW-1:0]  pos_q, pos_d;
  logic           arm_q, arm_d;
  logic [NCH-1:0] fill_q, fill_d;
  logic           done_q, done_d;
  logic           pend_q, pend_d;
  logic           act;
  logic [PW-1:0]  tgt_ch;
  logic [NCH-1:0] wr_en;
  logic           xfr_go;

  function automatic logic [PW-1:0] ch_of(input logic [PW-1:0] p, input logic r);
    return r ? (LAST - p) : p;
  endfunction

  always_comb begin
    act    = (rise_ph_i == edge_sel_i);
    st_d   = st_q;
    pos_d  = pos_q;
    arm_d  = arm_q;
    fill_d = fill_q;
    done_d = 1'b0;
    wr_en  = '0;
    tgt_ch = ch_of(pos_q, rev_i);
    xfr_go = ~rise_ph_i & pend_q;
    pend_d = pend_q;
    if (xfr_go) pend_d = 1'b0;
    if (rise_ph_i && xfr_i) pend_d = 1'b1;
    if (act) begin
      arm_d = start_i;
      if (arm_q) begin
        tgt_ch         = ch_of('0, rev_i);
        wr_en[tgt_ch]  = 1'b1;
        fill_d         = '0;
        fill_d[tgt_ch] = 1'b1;
        st_d           = SEQ_RUN;
        pos_d          = PW'(1);
      end else if (st_q == SEQ_RUN) begin
        wr_en[tgt_ch]  = 1'b1;
        fill_d[tgt_ch] = 1'b1;
        if (pos_q == LAST) begin
          st_d   = SEQ_IDLE;
          pos_d  = '0;
          done_d = 1'b1;
        end else begin
          pos_d = pos_q + PW'(1);
        end
      end
    end
    if (stby_i) begin
      st_d   = SEQ_IDLE;
      pos_d  = '0;
      arm_d  = 1'b0;
      fill_d = '0;
      done_d = 1'b0;
      pend_d = 1'b0;
      wr_en  = '0;
      xfr_go = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      pos_q  <= '0;
      arm_q  <= 1'b0;
      fill_q <= '0;
      done_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      arm_q  <= arm_d;
      fill_q <= fill_d;
      done_q <= done_d;
      pend_q <= pend_d;
    end
  end

  assign wr_en_o  = wr_en;
  assign fill_o   = fill_q;
  assign done_o   = done_q;
  assign xfr_go_o = xfr_go;

  // R3
  wr_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_en_o) |-> (rise_ph_i == edge_sel_i));
  // R4
  wr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  // R5
  done_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (&fill_o));
  // R7
  xfr_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfr_go_o |-> (!rise_ph_i && $past(rise_ph_i && xfr_i)));
  // R9
  stby_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> (fill_o == '0 && st_q == SEQ_IDLE && !done_o));
endmodule

// File: rtl/colfeed_lane.sv
module colfeed_lane
  import colfeed_pkg::*;
#(
  parameter int unsigned DW = CF_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stby_i,
  input  logic          ld_i,
  input  logic          xfr_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] code_o
);
  logic [DW-1:0] stage_q, stage_d;
  logic [DW-1:0] hold_q, hold_d;

  always_comb begin
    stage_d = stage_q;
    hold_d  = hold_q;
    if (ld_i)  stage_d = word_i;
    if (xfr_i) hold_d  = stage_q;
    if (stby_i) begin
      stage_d = '0;
      hold_d  = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      stage_q <= stage_d;
      hold_q  <= hold_d;
    end
  end

  assign code_o = hold_q;

  // R7
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfr_i && !stby_i) |=> $stable(code_o));
  // R5
  stage_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !stby_i) |=> $stable(stage_q));
endmodule

// File: rtl/colfeed_polarity.sv
module colfeed_polarity
  import colfeed_pkg::*;
#(
  parameter int unsigned DW = CF_DW
) (
  input  logic          inv_i,
  input  logic [DW-1:0] code_i,
  output logic [DW:0]   ofs_o
);
  localparam logic [DW:0] FS = {1'b0, {DW{1'b1}}};
  logic [DW:0] mag;

  always_comb begin
    mag   = FS - {1'b0, code_i};
    ofs_o = inv_i ? mag : (~mag + {{DW{1'b0}}, 1'b1});
  end
endmodule

// File: rtl/colfeed_loader.sv
module colfeed_loader
  import colfeed_pkg::*;
#(
  parameter int unsigned NCH = CF_NCH,
  parameter int unsigned DW  = CF_DW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rise_ph_i,
  input  logic                  edge_sel_i,
  input  logic                  rev_i,
  input  logic                  start_i,
  input  logic                  xfr_i,
  input  logic                  inv_i,
  input  logic                  stby_i,
  input  logic [DW-1:0]         word_i,
  output logic [NCH*DW-1:0]     hold_code_o,
  output logic [NCH*(DW+1)-1:0] offset_o,
  output logic [NCH-1:0]        fill_o,
  output logic                  done_o
);
  localparam int unsigned OW = DW + 1;

  logic [1:0]     rst_sync_q;
  logic           rst_n;
  logic [NCH-1:0] wr_en;
  logic           xfr_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  colfeed_seq #(.NCH(NCH)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .stby_i     (stby_i),
    .rise_ph_i  (rise_ph_i),
    .edge_sel_i (edge_sel_i),
    .rev_i      (rev_i),
    .start_i    (start_i),
    .xfr_i      (xfr_i),
    .wr_en_o    (wr_en),
    .fill_o     (fill_o),
    .done_o     (done_o),
    .xfr_go_o   (xfr_go)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] code_w;
    logic [OW-1:0] ofs_w;

    colfeed_lane #(.DW(DW)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .stby_i (stby_i),
      .ld_i   (wr_en[i]),
      .xfr_i  (xfr_go),
      .word_i (word_i),
      .code_o (code_w)
    );

    colfeed_polarity #(.DW(DW)) u_pol (
      .inv_i  (inv_i),
      .code_i (code_w),
      .ofs_o  (ofs_w)
    );

    assign hold_code_o[i*DW +: DW] = code_w;
    assign offset_o[i*OW +: OW]    = ofs_w;

    // R8
    neg_region_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      !inv_i |-> (ofs_w[OW-1] || ofs_w == '0));
    // R8
    pos_region_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      inv_i |-> !ofs_w[OW-1]);
  end
endmodule

// File: tb/colfeed_loader_test.sv
module colfeed_loader_test;
  localparam int NCH = 6;
  localparam int DW  = 10;

  typedef struct packed {
    logic [NCH*DW-1:0] codes;
    logic [NCH-1:0]    fill;
    logic              done;
    logic              inv;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni;
  logic rise_ph_i, edge_sel_i, rev_i, start_i, xfr_i, inv_i, stby_i;
  logic [DW-1:0] word_i;
  logic [NCH*DW-1:0]     hold_code_o;
  logic [NCH*(DW+1)-1:0] offset_o;
  logic [NCH-1:0]        fill_o;
  logic                  done_o;

  colfeed_loader uut (
    .clk_i(clk), .rst_ni(rst_ni), .rise_ph_i(rise_ph_i), .edge_sel_i(edge_sel_i),
    .rev_i(rev_i), .start_i(start_i), .xfr_i(xfr_i), .inv_i(inv_i), .stby_i(stby_i),
    .word_i(word_i), .hold_code_o(hold_code_o), .offset_o(offset_o),
    .fill_o(fill_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit finished = 1'b0;
  bit mon_on = 1'b0;

  logic c_edge = 1'b1, c_rev = 1'b0, c_inv = 1'b0, c_stby = 1'b0;
  string cur_tag = "R1";

  logic [DW-1:0] m_s1 [NCH];
  logic [DW-1:0] m_out[NCH];
  logic [NCH-1:0] m_fill;
  logic m_arm, m_busy, m_pend, m_done;
  int   m_pos;

  exp_t  exp_q[$];
  string tag_q[$];

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ofs_of(int code, logic inv);
    int m = 1023 - code;
    return inv ? m : -m;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin m_s1[i] = '0; m_out[i] = '0; end
    m_fill = '0; m_arm = 0; m_busy = 0; m_pend = 0; m_done = 0; m_pos = 0;
  endtask

  task automatic model_step(logic ph, logic st, logic xf, logic [DW-1:0] w);
    logic act, old_arm, npend;
    int ch;
    if (c_stby) begin model_reset(); return; end
    act = (ph == c_edge);
    m_done = 0;
    npend = m_pend;
    if (!ph && m_pend) begin
      for (int i = 0; i < NCH; i++) m_out[i] = m_s1[i];
      npend = 0;
    end
    if (ph && xf) npend = 1;
    m_pend = npend;
    if (act) begin
      old_arm = m_arm;
      m_arm = st;
      if (old_arm) begin
        ch = c_rev ? NCH-1 : 0;
        m_s1[ch] = w; m_fill = '0; m_fill[ch] = 1'b1;
        m_busy = 1; m_pos = 1;
      end else if (m_busy) begin
        ch = c_rev ? NCH-1-m_pos : m_pos;
        m_s1[ch] = w; m_fill[ch] = 1'b1;
        if (m_pos == NCH-1) begin m_busy = 0; m_pos = 0; m_done = 1; end
        else m_pos++;
      end
    end
  endtask

  // one fast cycle: drive at negedge, predict, push expectation
  task automatic cyc(logic ph, logic st, logic xf, logic [DW-1:0] w);
    exp_t e;
    @(negedge clk);
    rise_ph_i = ph; start_i = st; xfr_i = xf; word_i = w;
    edge_sel_i = c_edge; rev_i = c_rev; inv_i = c_inv; stby_i = c_stby;
    model_step(ph, st, xf, w);
    for (int i = 0; i < NCH; i++) e.codes[i*DW +: DW] = m_out[i];
    e.fill = m_fill; e.done = m_done; e.inv = c_inv;
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
  endtask

  task automatic pix(logic sr, logic sf, logic xf, logic [DW-1:0] wr, logic [DW-1:0] wf);
    cyc(1'b1, sr, xf, wr);
    cyc(1'b0, sf, 1'b0, wf);
  endtask

  task automatic settle();
    @(posedge clk); #3;
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    string t;
    forever begin
      @(posedge clk); #2;
      if (mon_on && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        for (int i = 0; i < NCH; i++) begin
          check(t, $sformatf("code ch%0d", i), int'(hold_code_o[i*DW +: DW]),
                int'(e.codes[i*DW +: DW]));
          check("R8", $sformatf("offset ch%0d", i),
                int'($signed(offset_o[i*(DW+1) +: DW+1])),
                ofs_of(int'(e.codes[i*DW +: DW]), e.inv));
        end
        check("R10", "fill", int'(fill_o), int'(e.fill));
        check("R5", "done", int'(done_o), int'(e.done));
      end
    end
  end

  initial begin
    #1ms;
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    rst_ni = 1'b0; rise_ph_i = 0; start_i = 0; xfr_i = 0; word_i = '0;
    edge_sel_i = 1; rev_i = 0; inv_i = 0; stby_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NCH; i++) begin
      check("R1", "reset code", int'(hold_code_o[i*DW +: DW]), 0);
      check("R1", "reset offset", int'($signed(offset_o[i*(DW+1) +: DW+1])), -1023);
    end
    check("R1", "reset fill", int'(fill_o), 0);
    check("R1", "reset done", int'(done_o), 0);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    repeat (3) pix(0, 0, 0, 0, 0);

    // A: rising mode, ascending; fall-half words are decoys (R3)
    c_edge = 1; c_rev = 0; cur_tag = "R2";
    pix(1, 0, 0, 10'd999, 10'd998);
    for (int k = 0; k < NCH; k++) pix(0, 0, 0, 10'(100+k), 10'(500+k));
    cur_tag = "R5";
    pix(0, 0, 0, 10'd777, 10'd778);
    pix(0, 0, 0, 10'd779, 10'd780);
    cur_tag = "R7";
    pix(0, 0, 1, 0, 0);
    pix(0, 0, 0, 0, 0);
    settle();
    for (int k = 0; k < NCH; k++)
      check("R3", "rising-mode code", int'(hold_code_o[k*DW +: DW]), 100+k);

    // B: falling mode, descending, transfer after load overlapping display (R4, R7)
    c_edge = 0; c_rev = 1; cur_tag = "R4";
    pix(0, 1, 0, 10'd901, 10'd902);
    for (int k = 0; k < 3; k++) pix(0, 0, 0, 10'(600+k), 10'(200+k));
    settle();
    check("R10", "partial fill descending", int'(fill_o), 6'b111000);
    for (int k = 0; k < NCH; k++)
      check("R7", "old code held", int'(hold_code_o[k*DW +: DW]), 100+k);
    for (int k = 3; k < NCH; k++) pix(0, 0, 0, 10'(600+k), 10'(200+k));
    cur_tag = "R7";
    pix(0, 0, 1, 0, 0);
    pix(0, 0, 0, 0, 0);
    settle();
    for (int k = 0; k < NCH; k++)
      check("R4", "descending code", int'(hold_code_o[(NCH-1-k)*DW +: DW]), 200+k);

    // C: restart mid-sequence (R6)
    c_edge = 1; c_rev = 0; cur_tag = "R6";
    pix(1, 0, 0, 0, 0);
    pix(0, 0, 0, 10'd300, 0);
    pix(0, 0, 0, 10'd301, 0);
    pix(1, 0, 0, 10'd302, 0);
    for (int k = 0; k < NCH; k++) pix(0, 0, 0, 10'(400+k), 0);
    pix(0, 0, 1, 0, 0);
    pix(0, 0, 0, 0, 0);
    settle();
    for (int k = 0; k < NCH; k++)
      check("R6", "restart code", int'(hold_code_o[k*DW +: DW]), 400+k);

    // D: standby in mid-sequence (R9)
    cur_tag = "R9";
    pix(1, 0, 0, 0, 0);
    pix(0, 0, 0, 10'd50, 0);
    pix(0, 0, 0, 10'd51, 0);
    c_stby = 1;
    pix(0, 0, 0, 10'd52, 0);
    c_stby = 0;
    settle();
    for (int k = 0; k < NCH; k++)
      check("R9", "standby code", int'(hold_code_o[k*DW +: DW]), 0);
    check("R9", "standby fill", int'(fill_o), 0);
    pix(0, 0, 0, 10'd53, 0);
    pix(0, 0, 1, 0, 0);
    pix(0, 0, 0, 0, 0);
    pix(1, 0, 0, 0, 0);
    for (int k = 0; k < NCH; k++) pix(0, 0, 0, 10'(k == 0 ? 0 : (k == 1 ? 1023 : 700+k)), 0);
    pix(0, 0, 1, 0, 0);
    pix(0, 0, 0, 0, 0);
    settle();
    check("R9", "resume ch1", int'(hold_code_o[DW +: DW]), 1023);

    // E: polarity at code boundaries (R8)
    cur_tag = "R8";
    check("R8", "code0 inv low", int'($signed(offset_o[0 +: DW+1])), -1023);
    check("R8", "code1023 inv low", int'($signed(offset_o[(DW+1) +: DW+1])), 0);
    c_inv = 1;
    pix(0, 0, 0, 0, 0);
    settle();
    check("R8", "code0 inv high", int'($signed(offset_o[0 +: DW+1])), 1023);
    check("R8", "code1023 inv high", int'($signed(offset_o[(DW+1) +: DW+1])), 0);
    check("R8", "code702 inv high", int'($signed(offset_o[2*(DW+1) +: DW+1])), 321);
    pix(0, 0, 0, 0, 0);

    repeat (2) @(posedge clk);
    #3;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule